// File: doc/BRIEF.md
# Core-to-Host Indirect Register Bridge

This block gives an embedded core access to a bank of peripheral registers that the host also owns. There is one physical register bank, so every access goes through a single request/acknowledge port with variable latency. The core does not drive that port directly. It programs a small window of its own registers: a device select, a register offset, a data byte and a control byte. It starts a read by setting a start bit in the control byte. It starts a write by storing a byte into the data register. Configuration index/data registers are reached like any other device number.

An arbiter state machine lets through either a host transfer or a core transfer, and never both at once. When both sides wait in the same cycle, it alternates between them. A 32-bit lock mask, set by the core through the same window, keeps the host out of chosen devices. A locked host write is dropped. A locked host read returns all ones. Neither of them reaches the bank.

The arbiter has four states: IDLE, CORE (core transfer on the bank), HOST (host transfer on the bank) and DENY (one-cycle reply to a blocked host request). The transitions are:
- IDLE to CORE when the core wins arbitration.
- IDLE to HOST when the host wins arbitration and its device is unlocked.
- IDLE to DENY when the host wins arbitration and its device is locked.
- CORE and HOST back to IDLE on bank acknowledge.
- DENY back to IDLE after one cycle.

Top module: `corehost_bridge`

## Requirements
- R1: After reset, all eight window registers read 0 and the lock mask is clear. Window address 0 is the device select, 1 the offset, 2 the data register, 3 the control byte, and 4..7 the lock mask bytes, low byte first. In the control byte, bit 0 is read-busy and bit 1 is write-busy. After reset `bank_req` and `host_ack` are low.
- R2: Writing a control byte with bit 0 = 1 sets read-busy. Read-busy stays 1 until the bank acknowledges a read of the selected device/offset, then clears. From then on, address 2 returns the byte the bank supplied.
- R3: Writing address 2 stores the byte and sets write-busy. The byte is then written to the selected device/offset. Write-busy reads 1 until the bank acknowledges, then clears.
- R4: While read-busy or write-busy is set, core window writes are ignored, including writes to the device select.
- R5: Once `bank_req` rises, it stays high, and device, offset, direction and write data stay stable, until `bank_ack`. Only one transfer occupies the bank at a time.
- R6: A host request to an unlocked device is carried out on the bank. `host_ack` pulses for one cycle, together with the bank's read data.
- R7: A host request to a locked device never raises `bank_req`. It is answered one cycle after arbitration with `host_ack` and `host_rdata` = 0xFF, and a write is dropped.
- R8: When the host and the core both wait in IDLE, the one that was not served last wins. After reset the core counts as not served last.
- R9: Lock bit i (bit i%8 of window byte 4 + i/8) blocks every host device whose low 5 bits equal i. The lock bytes read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_wr_en | input | 1 | Core window write strobe |
| core_addr | input | 3 | Core window register address |
| core_wdata | input | 8 | Core window write data |
| core_rdata | output | 8 | Core window read data (combinational) |
| host_req | input | 1 | Host request, held until host_ack |
| host_we | input | 1 | Host direction, 1 = write |
| host_dev | input | 8 | Host device number |
| host_off | input | 8 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_ack | output | 1 | Host completion pulse |
| host_rdata | output | 8 | Host read data, valid with host_ack |
| bank_req | output | 1 | Register bank request |
| bank_we | output | 1 | Register bank direction, 1 = write |
| bank_dev | output | 8 | Register bank device number |
| bank_off | output | 8 | Register bank offset |
| bank_wdata | output | 8 | Register bank write data |
| bank_ack | input | 1 | Register bank completion |
| bank_rdata | input | 8 | Register bank read data, valid with bank_ack |

## Verification
The bench builds the block with its default parameters: 8-bit device, offset and data, and a 32-entry lock mask. With these values the lock occupies window addresses 4 to 7. The full lock index range, including bit 31, can be reached, and so can two device numbers that alias onto one lock bit. The bank model answers with a random latency of zero to three cycles. Busy windows, arbitration collisions and concurrent host and core streams are therefore exercised against a scoreboard under varying timing.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CORE,
        ST_HOST,
        ST_DENY
    } arb_state_t;

    localparam int WIN_AW = 3;
    localparam logic [WIN_AW-1:0] WIN_DEV   = 3'd0;
    localparam logic [WIN_AW-1:0] WIN_OFF   = 3'd1;
    localparam logic [WIN_AW-1:0] WIN_DATA  = 3'd2;
    localparam logic [WIN_AW-1:0] WIN_CTRL  = 3'd3;
    localparam logic [WIN_AW-1:0] WIN_LOCK0 = 3'd4;
endpackage

// File: rtl/cbr_window.sv
module cbr_window
    import cbr_pkg::*;
#(
    parameter int DEV_W  = 8,
    parameter int OFF_W  = 8,
    parameter int DATA_W = 8,
    parameter int LOCK_N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIN_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DEV_W-1:0]  dev_sel,
    output logic [OFF_W-1:0]  off_sel,
    output logic [DATA_W-1:0] data_val,
    output logic              rd_busy,
    output logic              wr_busy,
    output logic [LOCK_N-1:0] lock_mask,
    input  logic              done,
    input  logic [DATA_W-1:0] done_rdata
);
    localparam int LOCK_BYTES = LOCK_N / DATA_W;

    logic busy;
    assign busy = rd_busy | wr_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_sel   <= '0;
            off_sel   <= '0;
            data_val  <= '0;
            rd_busy   <= 1'b0;
            wr_busy   <= 1'b0;
            lock_mask <= '0;
        end else if (done) begin
            rd_busy <= 1'b0;
            wr_busy <= 1'b0;
            if (rd_busy) data_val <= done_rdata;
        end else if (wr_en && !busy) begin
            case (addr)
                WIN_DEV:  dev_sel <= wdata[DEV_W-1:0];
                WIN_OFF:  off_sel <= wdata[OFF_W-1:0];
                WIN_DATA: begin
                    data_val <= wdata;
                    wr_busy  <= 1'b1;
                end
                WIN_CTRL: if (wdata[0]) rd_busy <= 1'b1;
                default: begin
                    for (int i = 0; i < LOCK_BYTES; i++) begin
                        if (addr == WIN_LOCK0 + WIN_AW'(i))
                            lock_mask[i*DATA_W +: DATA_W] <= wdata;
                    end
                end
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            WIN_DEV:  rdata = DATA_W'(dev_sel);
            WIN_OFF:  rdata = DATA_W'(off_sel);
            WIN_DATA: rdata = data_val;
            WIN_CTRL: rdata = {{(DATA_W-2){1'b0}}, wr_busy, rd_busy};
            default: begin
                for (int i = 0; i < LOCK_BYTES; i++) begin
                    if (addr == WIN_LOCK0 + WIN_AW'(i))
                        rdata = lock_mask[i*DATA_W +: DATA_W];
                end
            end
        endcase
    end
endmodule

// File: rtl/cbr_arbiter.sv
module cbr_arbiter
    import cbr_pkg::*;
#(
    parameter int DEV_W  = 8,
    parameter int OFF_W  = 8,
    parameter int DATA_W = 8,
    parameter int LOCK_N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_pend,
    input  logic              core_we,
    input  logic [DEV_W-1:0]  core_dev,
    input  logic [OFF_W-1:0]  core_off,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_done,
    output logic [DATA_W-1:0] core_rdata,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [DEV_W-1:0]  host_dev,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [LOCK_N-1:0] lock_mask,
    output logic              bank_req,
    output logic              bank_we,
    output logic [DEV_W-1:0]  bank_dev,
    output logic [OFF_W-1:0]  bank_off,
    output logic [DATA_W-1:0] bank_wdata,
    input  logic              bank_ack,
    input  logic [DATA_W-1:0] bank_rdata
);
    localparam int LOCK_IDX_W = $clog2(LOCK_N);

    arb_state_t state, nxt;
    logic       last_host;
    logic       core_go, host_go, host_locked;

    assign host_locked = lock_mask[host_dev[LOCK_IDX_W-1:0]];
    assign core_go     = core_pend && (!host_req || last_host);
    assign host_go     = host_req && !core_go;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (core_go)      nxt = ST_CORE;
                else if (host_go) nxt = host_locked ? ST_DENY : ST_HOST;
            end
            ST_CORE: if (bank_ack) nxt = ST_IDLE;
            ST_HOST: if (bank_ack) nxt = ST_IDLE;
            ST_DENY: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            last_host  <= 1'b1;
            bank_we    <= 1'b0;
            bank_dev   <= '0;
            bank_off   <= '0;
            bank_wdata <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && core_go) begin
                last_host  <= 1'b0;
                bank_we    <= core_we;
                bank_dev   <= core_dev;
                bank_off   <= core_off;
                bank_wdata <= core_wdata;
            end else if (state == ST_IDLE && host_go) begin
                last_host  <= 1'b1;
                bank_we    <= host_we;
                bank_dev   <= host_dev;
                bank_off   <= host_off;
                bank_wdata <= host_wdata;
            end
        end
    end

    always_comb begin
        bank_req   = 1'b0;
        host_ack   = 1'b0;
        host_rdata = bank_rdata;
        core_done  = 1'b0;
        core_rdata = bank_rdata;
        unique case (state)
            ST_IDLE: ;
            ST_CORE: begin
                bank_req  = 1'b1;
                core_done = bank_ack;
            end
            ST_HOST: begin
                bank_req = 1'b1;
                host_ack = bank_ack;
            end
            ST_DENY: begin
                host_ack   = 1'b1;
                host_rdata = '1;
            end
        endcase
    end
endmodule

// File: rtl/corehost_bridge.sv
module corehost_bridge
    import cbr_pkg::*;
#(
    parameter int DEV_W  = 8,
    parameter int OFF_W  = 8,
    parameter int DATA_W = 8,
    parameter int LOCK_N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_wr_en,
    input  logic [WIN_AW-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [DEV_W-1:0]  host_dev,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              bank_req,
    output logic              bank_we,
    output logic [DEV_W-1:0]  bank_dev,
    output logic [OFF_W-1:0]  bank_off,
    output logic [DATA_W-1:0] bank_wdata,
    input  logic              bank_ack,
    input  logic [DATA_W-1:0] bank_rdata
);
    logic [DEV_W-1:0]  win_dev;
    logic [OFF_W-1:0]  win_off;
    logic [DATA_W-1:0] win_data;
    logic              win_rd_busy, win_wr_busy;
    logic [LOCK_N-1:0] win_lock;
    logic              xfer_done;
    logic [DATA_W-1:0] xfer_rdata;

    cbr_window #(.DEV_W(DEV_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .LOCK_N(LOCK_N)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (core_wr_en),
        .addr       (core_addr),
        .wdata      (core_wdata),
        .rdata      (core_rdata),
        .dev_sel    (win_dev),
        .off_sel    (win_off),
        .data_val   (win_data),
        .rd_busy    (win_rd_busy),
        .wr_busy    (win_wr_busy),
        .lock_mask  (win_lock),
        .done       (xfer_done),
        .done_rdata (xfer_rdata)
    );

    cbr_arbiter #(.DEV_W(DEV_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .LOCK_N(LOCK_N)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_pend  (win_rd_busy | win_wr_busy),
        .core_we    (win_wr_busy),
        .core_dev   (win_dev),
        .core_off   (win_off),
        .core_wdata (win_data),
        .core_done  (xfer_done),
        .core_rdata (xfer_rdata),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_dev   (host_dev),
        .host_off   (host_off),
        .host_wdata (host_wdata),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .lock_mask  (win_lock),
        .bank_req   (bank_req),
        .bank_we    (bank_we),
        .bank_dev   (bank_dev),
        .bank_off   (bank_off),
        .bank_wdata (bank_wdata),
        .bank_ack   (bank_ack),
        .bank_rdata (bank_rdata)
    );
endmodule

// File: rtl/cbr_checks.sv
module cbr_checks #(
    parameter int DEV_W  = 8,
    parameter int OFF_W  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bank_req,
    input logic              bank_ack,
    input logic              bank_we,
    input logic [DEV_W-1:0]  bank_dev,
    input logic [OFF_W-1:0]  bank_off,
    input logic [DATA_W-1:0] bank_wdata,
    input logic              host_ack,
    input logic [DATA_W-1:0] host_rdata,
    input logic              rd_busy,
    input logic              wr_busy
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_req && !bank_ack) |=> (bank_req && $stable(bank_dev) && $stable(bank_off) && $stable(bank_we) && $stable(bank_wdata))); // R5
    AST_DENY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !bank_req) |-> (host_rdata == '1)); // R7
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack); // R6
    AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_busy) |-> $past(bank_ack)); // R2
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && !bank_ack) |=> wr_busy); // R3
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_busy && wr_busy)); // R4
endmodule

bind corehost_bridge cbr_checks #(.DEV_W(DEV_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_req   (bank_req),
    .bank_ack   (bank_ack),
    .bank_we    (bank_we),
    .bank_dev   (bank_dev),
    .bank_off   (bank_off),
    .bank_wdata (bank_wdata),
    .host_ack   (host_ack),
    .host_rdata (host_rdata),
    .rd_busy    (win_rd_busy),
    .wr_busy    (win_wr_busy)
);

// File: tb/corehost_bridge_test.sv
module corehost_bridge_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_wr_en = 1'b0;
    logic [2:0] core_addr = '0;
    logic [7:0] core_wdata = '0;
    logic [7:0] core_rdata;
    logic       host_req = 1'b0, host_we = 1'b0;
    logic [7:0] host_dev = '0, host_off = '0, host_wdata = '0;
    logic       host_ack;
    logic [7:0] host_rdata;
    logic       bank_req, bank_we;
    logic [7:0] bank_dev, bank_off, bank_wdata;
    logic       bank_ack = 1'b0;
    logic [7:0] bank_rdata = '0;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int lat = 0;
    int grants = 0;
    logic prev_req = 1'b0;
    logic [7:0] glog [64];

    always #5 clk = ~clk;

    corehost_bridge uut (
        .clk(clk), .rst_n(rst_n),
        .core_wr_en(core_wr_en), .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .host_req(host_req), .host_we(host_we), .host_dev(host_dev), .host_off(host_off),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .bank_req(bank_req), .bank_we(bank_we), .bank_dev(bank_dev), .bank_off(bank_off),
        .bank_wdata(bank_wdata), .bank_ack(bank_ack), .bank_rdata(bank_rdata)
    );

    // bank model with random latency
    always @(negedge clk) begin
        if (bank_ack) begin
            bank_ack = 1'b0;
            lat = $urandom_range(3, 0);
        end else if (bank_req) begin
            if (lat == 0) begin
                bank_ack = 1'b1;
                bank_rdata = mem[{bank_dev[3:0], bank_off[3:0]}];
                if (bank_we) mem[{bank_dev[3:0], bank_off[3:0]}] = bank_wdata;
            end else begin
                lat = lat - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (bank_req && !prev_req) begin
            glog[grants % 64] = bank_dev;
            grants = grants + 1;
        end
        prev_req = bank_req;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic core_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        core_wr_en = 1'b1; core_addr = a; core_wdata = d;
        @(negedge clk);
        core_wr_en = 1'b0;
    endtask

    task automatic core_peek(input logic [2:0] a, output logic [7:0] d);
        core_addr = a;
        #1;
        d = core_rdata;
    endtask

    task automatic core_wait_idle();
        logic [7:0] c;
        forever begin
            @(negedge clk); #2;
            core_peek(3'd3, c);
            if (c[1:0] == 2'b00) break;
        end
    endtask

    task automatic core_bank_write(input logic [7:0] dv, input logic [7:0] of, input logic [7:0] d);
        core_wr(3'd0, dv); core_wr(3'd1, of); core_wr(3'd2, d);
        exp_mem[{dv[3:0], of[3:0]}] = d;
        core_wait_idle();
    endtask

    task automatic core_bank_read(input logic [7:0] dv, input logic [7:0] of, output logic [7:0] d);
        core_wr(3'd0, dv); core_wr(3'd1, of); core_wr(3'd3, 8'h01);
        core_wait_idle();
        core_peek(3'd2, d);
    endtask

    task automatic host_access(input bit now, input logic we, input logic [7:0] dv,
                               input logic [7:0] of, input logic [7:0] d, output logic [7:0] r);
        if (!now) @(negedge clk);
        host_req = 1'b1; host_we = we; host_dev = dv; host_off = of; host_wdata = d;
        forever begin
            @(negedge clk); #2;
            if (host_ack) begin
                r = host_rdata;
                host_req = 1'b0;
                break;
            end
        end
    endtask

    typedef struct packed {
        logic [1:0] op;   // 0 core write, 1 core read, 2 host write, 3 host read
        logic [7:0] dev;
        logic [7:0] off;
        logic [7:0] data;
        logic [7:0] expv;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 8'd1, 8'd2,  8'hA5, 8'h00},
        '{2'd3, 8'd1, 8'd2,  8'h00, 8'hA5},
        '{2'd2, 8'd3, 8'd4,  8'h3C, 8'h00},
        '{2'd1, 8'd3, 8'd4,  8'h00, 8'h3C},
        '{2'd0, 8'd5, 8'd0,  8'hFF, 8'h00},
        '{2'd1, 8'd5, 8'd0,  8'h00, 8'hFF},
        '{2'd2, 8'd0, 8'd15, 8'h81, 8'h00},
        '{2'd3, 8'd0, 8'd15, 8'h00, 8'h81}
    };

    initial begin
        logic [7:0] r;
        int g0;
        for (int i = 0; i < 256; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 bank_req", {31'd0, bank_req}, 0);
        chk("R1 host_ack", {31'd0, host_ack}, 0);
        for (int a = 0; a < 8; a++) begin
            core_peek(3'(a), r);
            chk("R1 window", {24'd0, r}, 0);
        end
        rst_n = 1'b1;

        // table walk: R2 R3 R6
        for (int v = 0; v < 8; v++) begin
            unique case (VECS[v].op)
                2'd0: core_bank_write(VECS[v].dev, VECS[v].off, VECS[v].data);
                2'd1: begin
                    core_bank_read(VECS[v].dev, VECS[v].off, r);
                    chk("R2 core read", {24'd0, r}, {24'd0, VECS[v].expv});
                end
                2'd2: host_access(0, 1'b1, VECS[v].dev, VECS[v].off, VECS[v].data, r);
                2'd3: begin
                    host_access(0, 1'b0, VECS[v].dev, VECS[v].off, 8'h00, r);
                    chk("R6 host read", {24'd0, r}, {24'd0, VECS[v].expv});
                end
            endcase
        end

        // R3 write-busy visible, then clears
        core_wr(3'd0, 8'd7); core_wr(3'd1, 8'd7); core_wr(3'd2, 8'h5E);
        core_peek(3'd3, r);
        chk("R3 wr busy", {24'd0, r}, 32'h02);
        core_wait_idle();
        core_peek(3'd3, r);
        chk("R3 wr clear", {24'd0, r}, 0);
        core_bank_read(8'd7, 8'd7, r);
        chk("R3 write landed", {24'd0, r}, 32'h5E);

        // R2 read-busy visible right after start
        core_wr(3'd3, 8'h01);
        core_peek(3'd3, r);
        chk("R2 rd busy", {24'd0, r}, 32'h01);
        core_wait_idle();

        // R4 window write ignored while busy
        core_wr(3'd0, 8'd6); core_wr(3'd1, 8'd6); core_wr(3'd2, 8'h11);
        core_wr(3'd0, 8'h99);
        core_wait_idle();
        core_peek(3'd0, r);
        chk("R4 dev kept", {24'd0, r}, 32'h06);

        // R8 round robin: core served last, so host wins a tie
        core_bank_write(8'd9, 8'd0, 8'h01);
        g0 = grants;
        core_wr(3'd0, 8'd9); core_wr(3'd1, 8'd1); core_wr(3'd2, 8'h42);
        host_access(1, 1'b1, 8'd10, 8'd1, 8'h24, r);
        core_wait_idle();
        chk("R8 host first", {24'd0, glog[g0 % 64]}, 32'd10);
        chk("R8 core second", {24'd0, glog[(g0 + 1) % 64]}, 32'd9);

        // concurrent traffic, then scoreboard readback (R5 R8)
        fork
            for (int i = 0; i < 8; i++) core_bank_write(8'(i), 8'(i), 8'(i * 3 + 1));
            for (int i = 0; i < 8; i++) begin
                logic [7:0] hr;
                exp_mem[{4'(8 + i), 4'(i)}] = 8'(i * 5 + 2);
                host_access(0, 1'b1, 8'(8 + i), 8'(i), 8'(i * 5 + 2), hr);
            end
        join
        for (int i = 0; i < 16; i++) begin
            core_bank_read(8'(i), 8'(i % 8), r);
            chk("R5 scoreboard", {24'd0, r}, {24'd0, exp_mem[{4'(i), 4'(i % 8)}]});
        end

        // R9 lock mask programming and readback
        core_wr(3'd4, 8'h04);
        core_wr(3'd7, 8'h80);
        core_peek(3'd4, r);
        chk("R9 lock byte0", {24'd0, r}, 32'h04);
        core_peek(3'd7, r);
        chk("R9 lock byte3", {24'd0, r}, 32'h80);

        // R7 locked device: no bank access, ones returned, write dropped
        g0 = grants;
        host_access(0, 1'b1, 8'd2, 8'd1, 8'h77, r);
        chk("R7 write no bank", grants, g0);
        host_access(0, 1'b0, 8'd2, 8'd1, 8'h00, r);
        chk("R7 read ones", {24'd0, r}, 32'hFF);
        chk("R7 read no bank", grants, g0);
        host_access(0, 1'b0, 8'd34, 8'd1, 8'h00, r);
        chk("R9 alias dev34", {24'd0, r}, 32'hFF);
        host_access(0, 1'b1, 8'd63, 8'd0, 8'h12, r);
        chk("R9 bit31 no bank", grants, g0);
        core_bank_read(8'd2, 8'd1, r);
        chk("R7 write dropped", {24'd0, r}, 0);
        g0 = grants;
        host_access(0, 1'b1, 8'd3, 8'd1, 8'h66, r);
        chk("R9 unlocked dev3", grants, g0 + 1);
        core_bank_read(8'd3, 8'd1, r);
        chk("R6 unlocked data", {24'd0, r}, 32'h66);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog R5 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule